// File: doc/BRIEF.md
# Serial Character Buffer Register Front End

This block sits between a memory-mapped bus and the character path of a simple serial port. It holds one received character and one character waiting to be sent, and it runs the small amount of control logic around them. The bit-level shifter, the baud generator and the framing logic are outside the block. Handshake ports stand in for them: a load strobe with a character on the receive side, and a transmit-clock tick, a start pulse and a frame-done strobe on the transmit side.

A received character is latched into the receive buffer. The block then sets a data-available flag and gives a one-cycle interrupt pulse. Software reads the character with either an 8-bit or a 16-bit bus access, and only the 16-bit access acknowledges it and clears the flag. A bus write to the transmit buffer starts a frame after a fixed number of transmit-clock ticks, and the block stays busy until the shifter reports that the frame is done. A write that arrives while a frame is in flight is held and sent next. A mode input selects 7-bit or 8-bit characters. In 7-bit mode the most significant data bit is cleared on the receive read path and on the transmit output.

Top module: `serial_data_buffer`

## Requirements
- R1: After reset, both buffers hold 0x00, the flags rx_avail, rx_irq, rx_overrun, tx_busy and tx_start are low, and a read of either address returns 0x0000.
- R2: A cycle with rx_load high stores rx_char. In the next cycle rx_avail is high and rx_irq pulses high for exactly one cycle. A read at bus_addr 0 returns the stored character on bus_rdata[7:0] with bus_rdata[15:8] zero.
- R3: A 16-bit read (bus_wide=1) at bus_addr 0 clears rx_avail and rx_overrun from the next cycle on.
- R4: An 8-bit read (bus_wide=0) at bus_addr 0 leaves rx_avail unchanged.
- R5: With mode7=1, bus_rdata[7] reads 0 at bus_addr 0 whatever character was received.
- R6: A bus write at bus_addr 0 changes neither the receive buffer nor rx_avail.
- R7: If rx_load arrives while rx_avail is high and no 16-bit receive read happens in that cycle, the new character replaces the old one and rx_overrun goes high and stays high.
- R8: If rx_load and a 16-bit receive read happen in the same cycle, the read returns the old character, rx_avail stays high, and rx_overrun is not set.
- R9: A write at bus_addr 1 to an idle transmitter makes tx_busy high in the next cycle. tx_start then pulses for one cycle after START_TICKS (default 3) tx_tick cycles, and never after more than 4.
- R10: tx_char shows the transmit buffer with bit 7 forced to 0 when mode7=1, and all 8 bits when mode7=0.
- R11: A read at bus_addr 1 returns the last byte written there on bits 7:0 and ignores mode7.
- R12: tx_busy stays high until tx_done is seen after the frame has started. A write made while busy is held and reads back at once. After tx_done it becomes the next frame, tx_busy stays high, and it starts after START_TICKS further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = receive buffer, 1 = transmit buffer |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | 8 | Write data (low byte of the access) |
| bus_rdata | output | 16 | Read data, combinational from the selected buffer |
| mode7 | input | 1 | 1 = 7-bit characters, 0 = 8-bit characters |
| rx_load | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Character from the receive shifter |
| rx_avail | output | 1 | Receive data available flag |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| rx_overrun | output | 1 | Sticky overrun flag |
| tx_tick | input | 1 | Transmit clock enable, one cycle per transmit clock |
| tx_done | input | 1 | Transmit shifter finished the frame |
| tx_start | output | 1 | One-cycle frame start pulse to the shifter |
| tx_char | output | 8 | Character for the transmit shifter |
| tx_busy | output | 1 | Transmit in progress |

## Verification
Read data is combinational, so the bench samples bus_rdata in the middle of the access cycle. The flag changes caused by an access or by an rx_load appear one cycle later, behind a single register stage, and the bench checks them at the falling edge after the capturing edge. tx_start is registered from the tick that completes the count, so each tick is driven for one cycle and tx_start is sampled at the falling edge that follows. The count of ticks seen at that point must equal START_TICKS and be at most 4. tx_busy and the held-write restart likewise update one edge after tx_done and are checked at the next falling edge.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned BUS_W  = 16;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        char_t data;
        logic  avail;
        logic  irq;
        logic  ovr;
    } rx_state_t;
endpackage

// File: rtl/sdb_rx_side.sv
module sdb_rx_side
    import sdb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_i,
    input  char_t cap_data_i,
    input  logic  ack_i,
    output char_t data_o,
    output logic  avail_o,
    output logic  irq_o,
    output logic  ovr_o
);
    rx_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cap_i) begin
            st_d.data  = cap_data_i;
            st_d.avail = 1'b1;
            st_d.irq   = 1'b1;
        end else if (ack_i) begin
            st_d.avail = 1'b0;
        end
        // a lost character is one that arrives on top of an unacknowledged one
        if (cap_i && st_q.avail && !ack_i) begin
            st_d.ovr = 1'b1;
        end else if (ack_i) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign avail_o = st_q.avail;
    assign irq_o   = st_q.irq;
    assign ovr_o   = st_q.ovr;
endmodule

// File: rtl/sdb_tx_side.sv
module sdb_tx_side
    import sdb_pkg::*;
#(
    parameter int unsigned START_TICKS = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  char_t wdata_i,
    input  logic  tick_i,
    input  logic  done_i,
    output char_t view_o,
    output char_t buf_o,
    output logic  busy_o,
    output logic  start_o
);
    localparam int unsigned CNT_W = $clog2(START_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(START_TICKS - 1);

    typedef struct packed {
        char_t            cur;
        char_t            held;
        logic             held_vld;
        logic             busy;
        logic             wait_start;
        logic [CNT_W-1:0] cnt;
        logic             start;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic      frame_end;

    assign frame_end = st_q.busy && !st_q.wait_start && done_i;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        if (st_q.wait_start && tick_i) begin
            if (st_q.cnt == LAST_TICK) begin
                st_d.start      = 1'b1;
                st_d.wait_start = 1'b0;
                st_d.cnt        = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (frame_end) begin
            if (st_q.held_vld) begin
                st_d.cur        = st_q.held;
                st_d.wait_start = 1'b1;
                st_d.cnt        = '0;
                st_d.held_vld   = wr_i;
                if (wr_i) begin
                    st_d.held = wdata_i;
                end
            end else if (wr_i) begin
                st_d.cur        = wdata_i;
                st_d.wait_start = 1'b1;
                st_d.cnt        = '0;
            end else begin
                st_d.busy = 1'b0;
            end
        end else if (wr_i) begin
            if (st_q.busy) begin
                st_d.held     = wdata_i;
                st_d.held_vld = 1'b1;
            end else begin
                st_d.cur        = wdata_i;
                st_d.busy       = 1'b1;
                st_d.wait_start = 1'b1;
                st_d.cnt        = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign view_o  = st_q.held_vld ? st_q.held : st_q.cur;
    assign buf_o   = st_q.cur;
    assign busy_o  = st_q.busy;
    assign start_o = st_q.start;
endmodule

// File: rtl/serial_data_buffer.sv
module serial_data_buffer
    import sdb_pkg::*;
#(
    parameter int unsigned START_TICKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic        bus_wide,
    input  logic [7:0]  bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        mode7,
    input  logic        rx_load,
    input  logic [7:0]  rx_char,
    output logic        rx_avail,
    output logic        rx_irq,
    output logic        rx_overrun,
    input  logic        tx_tick,
    input  logic        tx_done,
    output logic        tx_start,
    output logic [7:0]  tx_char,
    output logic        tx_busy
);
    localparam logic ADDR_RX = 1'b0;
    localparam logic ADDR_TX = 1'b1;

    logic  rx_ack, tx_wr;
    char_t rx_data, tx_view, tx_cur;
    char_t msb_keep;

    assign rx_ack   = bus_req && !bus_we && bus_wide && (bus_addr == ADDR_RX);
    assign tx_wr    = bus_req && bus_we && (bus_addr == ADDR_TX);
    assign msb_keep = {~mode7, {(CHAR_W-1){1'b1}}};

    sdb_rx_side u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (rx_load),
        .cap_data_i(rx_char),
        .ack_i     (rx_ack),
        .data_o    (rx_data),
        .avail_o   (rx_avail),
        .irq_o     (rx_irq),
        .ovr_o     (rx_overrun)
    );

    sdb_tx_side #(.START_TICKS(START_TICKS)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (tx_wr),
        .wdata_i(bus_wdata),
        .tick_i (tx_tick),
        .done_i (tx_done),
        .view_o (tx_view),
        .buf_o  (tx_cur),
        .busy_o (tx_busy),
        .start_o(tx_start)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_TX) begin
            bus_rdata[CHAR_W-1:0] = tx_view;
        end else begin
            bus_rdata[CHAR_W-1:0] = rx_data & msb_keep;
        end
    end

    assign tx_char = tx_cur & msb_keep;
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_addr,
    input logic        bus_wide,
    input logic [15:0] bus_rdata,
    input logic        mode7,
    input logic        rx_load,
    input logic        rx_avail,
    input logic        rx_irq,
    input logic        rx_overrun,
    input logic        tx_tick,
    input logic        tx_done,
    input logic        tx_start,
    input logic [7:0]  tx_char,
    input logic        tx_busy
);
    logic       rd_rx_wide, rd_rx_narrow, wr_tx;
    logic       win_q;
    logic [3:0] win_cnt_q;

    assign rd_rx_wide   = bus_req && !bus_we && !bus_addr && bus_wide;
    assign rd_rx_narrow = bus_req && !bus_we && !bus_addr && !bus_wide;
    assign wr_tx        = bus_req && bus_we && bus_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= 1'b0;
            win_cnt_q <= '0;
        end else if (tx_start) begin
            win_q     <= 1'b0;
            win_cnt_q <= '0;
        end else if (wr_tx && !tx_busy) begin
            win_q     <= 1'b1;
            win_cnt_q <= '0;
        end else if (win_q && tx_tick && win_cnt_q != 4'hF) begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    a_r1_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:8] == 8'h00);

    a_r2_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (rx_avail && rx_irq));

    a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_load) |=> !rx_irq);

    a_r3_wide_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_wide && !rx_load) |=> (!rx_avail && !rx_overrun));

    a_r4_narrow_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_narrow && rx_avail) |=> rx_avail);

    a_r5_rx_msb_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode7 && bus_req && !bus_we && !bus_addr) |-> !bus_rdata[7]);

    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_avail && !rd_rx_wide) |=> rx_overrun);

    a_r8_arrival_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rd_rx_wide) |=> (rx_avail && !rx_overrun));

    a_r9_start_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_q |-> (win_cnt_q <= 4'd4));

    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    a_r10_tx_msb_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mode7 |-> !tx_char[7]);

    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_done) |=> tx_busy);
endmodule

bind serial_data_buffer sdb_checker u_sdb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wide  (bus_wide),
    .bus_rdata (bus_rdata),
    .mode7     (mode7),
    .rx_load   (rx_load),
    .rx_avail  (rx_avail),
    .rx_irq    (rx_irq),
    .rx_overrun(rx_overrun),
    .tx_tick   (tx_tick),
    .tx_done   (tx_done),
    .tx_start  (tx_start),
    .tx_char   (tx_char),
    .tx_busy   (tx_busy)
);

// File: tb/sim_serial_data_buffer.sv
`timescale 1ns/1ps
module sim_serial_data_buffer;
    localparam int START_TICKS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_addr = 1'b0, bus_wide = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mode7 = 1'b0;
    logic        rx_load = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_avail, rx_irq, rx_overrun;
    logic        tx_tick = 1'b0, tx_done = 1'b0;
    logic        tx_start, tx_busy;
    logic [7:0]  tx_char;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    serial_data_buffer #(.START_TICKS(START_TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mode7(mode7), .rx_load(rx_load),
        .rx_char(rx_char), .rx_avail(rx_avail), .rx_irq(rx_irq),
        .rx_overrun(rx_overrun), .tx_tick(tx_tick), .tx_done(tx_done),
        .tx_start(tx_start), .tx_char(tx_char), .tx_busy(tx_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic addr, input logic wide,
                          input logic [7:0] wd, output logic [15:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wide = wide; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] c);
        @(negedge clk);
        rx_load = 1'b1; rx_char = c;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    task automatic ticks_to_start(output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); tx_tick = 1'b1;
            @(negedge clk); tx_tick = 1'b0;
            n++;
            if (tx_start) break;
        end
    endtask

    task automatic frame_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] rd;
        check(!rx_avail && !rx_irq && !rx_overrun, "R1 rx flags", {rx_avail, rx_irq, rx_overrun}, 0);
        check(!tx_busy && !tx_start, "R1 tx flags", {tx_busy, tx_start}, 0);
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, rd);
        check(rd == 16'h0000, "R1 rx buffer", rd, 0);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00, rd);
        check(rd == 16'h0000, "R1 tx buffer", rd, 0);
    endtask

    task automatic t_rx_basic();
        logic [15:0] rd;
        rx_push(8'hA5);
        check(rx_avail && rx_irq, "R2 flags after capture", {rx_avail, rx_irq}, 3);
        @(negedge clk);
        check(!rx_irq && rx_avail, "R2 irq single pulse", {rx_avail, rx_irq}, 2);
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, rd);
        check(rd == 16'h00A5, "R2 narrow read data", rd, 16'h00A5);
        check(rx_avail, "R4 narrow read keeps flag", rx_avail, 1);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00, rd);
        check(rd == 16'h00A5, "R2 wide read data", rd, 16'h00A5);
        check(!rx_avail, "R3 wide read clears flag", rx_avail, 0);
    endtask

    task automatic t_rx_mode7();
        logic [15:0] rd;
        mode7 = 1'b1;
        rx_push(8'hFF);
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, rd);
        check(rd == 16'h007F, "R5 7-bit read masks bit 7", rd, 16'h007F);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00, rd);
        mode7 = 1'b0;
    endtask

    task automatic t_rx_write_ignored();
        logic [15:0] rd;
        bus_op(1'b1, 1'b0, 1'b1, 8'h33, rd);
        check(!rx_avail, "R6 write leaves flag", rx_avail, 0);
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, rd);
        check(rd == 16'h00FF, "R6 write leaves buffer", rd, 16'h00FF);
    endtask

    task automatic t_overrun();
        logic [15:0] rd;
        rx_push(8'h11);
        check(!rx_overrun, "R7 no overrun on first", rx_overrun, 0);
        rx_push(8'h22);
        check(rx_overrun, "R7 overrun set", rx_overrun, 1);
        repeat (3) @(negedge clk);
        check(rx_overrun, "R7 overrun sticky", rx_overrun, 1);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00, rd);
        check(rd == 16'h0022, "R7 newest character kept", rd, 16'h0022);
        check(!rx_overrun && !rx_avail, "R3 wide read clears overrun", {rx_overrun, rx_avail}, 0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] rd;
        rx_push(8'h44);
        @(negedge clk);
        rx_load = 1'b1; rx_char = 8'h55;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 1'b0; bus_wide = 1'b1;
        #1 rd = bus_rdata;
        @(negedge clk);
        rx_load = 1'b0; bus_req = 1'b0;
        check(rd == 16'h0044, "R8 read returns old character", rd, 16'h0044);
        check(rx_avail && !rx_overrun, "R8 arrival wins", {rx_avail, rx_overrun}, 2);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00, rd);
        check(rd == 16'h0055, "R8 new character stored", rd, 16'h0055);
    endtask

    task automatic t_tx_basic();
        logic [15:0] rd;
        int n;
        bus_op(1'b1, 1'b1, 1'b0, 8'hC3, rd);
        check(tx_busy, "R9 busy after write", tx_busy, 1);
        check(!tx_start, "R9 no early start", tx_start, 0);
        bus_op(1'b0, 1'b1, 1'b1, 8'h00, rd);
        check(rd == 16'h00C3, "R11 read back", rd, 16'h00C3);
        ticks_to_start(n);
        check(tx_start && n == START_TICKS && n <= 4, "R9 start after ticks", n, START_TICKS);
        check(tx_char == 8'hC3, "R10 8-bit character out", tx_char, 8'hC3);
        @(negedge clk);
        check(!tx_start, "R9 start single pulse", tx_start, 0);
        frame_done();
        check(!tx_busy, "R12 idle after done", tx_busy, 0);
    endtask

    task automatic t_tx_mode7();
        logic [15:0] rd;
        int n;
        mode7 = 1'b1;
        bus_op(1'b1, 1'b1, 1'b1, 8'h9A, rd);
        ticks_to_start(n);
        check(tx_start && n == START_TICKS, "R9 start in 7-bit mode", n, START_TICKS);
        check(tx_char == 8'h1A, "R10 7-bit drops bit 7", tx_char, 8'h1A);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00, rd);
        check(rd == 16'h009A, "R11 read back ignores mode", rd, 16'h009A);
        frame_done();
        mode7 = 1'b0;
    endtask

    task automatic t_tx_hold();
        logic [15:0] rd;
        int n;
        bus_op(1'b1, 1'b1, 1'b0, 8'h61, rd);
        ticks_to_start(n);
        bus_op(1'b1, 1'b1, 1'b0, 8'h62, rd);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00, rd);
        check(rd == 16'h0062, "R12 held write reads back", rd, 16'h0062);
        check(tx_char == 8'h61, "R12 frame in flight kept", tx_char, 8'h61);
        frame_done();
        check(tx_busy, "R12 busy across held write", tx_busy, 1);
        check(tx_char == 8'h62, "R12 held character loaded", tx_char, 8'h62);
        ticks_to_start(n);
        check(tx_start && n == START_TICKS, "R12 held frame starts", n, START_TICKS);
        frame_done();
        check(!tx_busy, "R12 idle after second done", tx_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_rx_mode7();
        t_rx_write_ignored();
        t_overrun();
        t_same_cycle();
        t_tx_basic();
        t_tx_mode7();
        t_tx_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule